// File: doc/BRIEF.md
# Calibrated Seconds Timekeeper

This block keeps wall-clock time as a 32-bit count of seconds. A slow oscillator supplies single-cycle enable pulses on `osc_tick`. A tick counter divides those pulses down to one seconds event per programmed period. A 21-bit calibration word sets that period: a 16-bit terminal count, a 4-bit fraction and a fraction enable. When the fraction is enabled, a 4-bit accumulator lengthens some seconds by one oscillator tick, so the long-term rate can be trimmed finer than one tick per second.

Software reaches the block through a single-cycle register port. Reads are combinational from `addr`, and a write happens on any cycle with `wr_en` high. A new time is staged first and only replaces the running seconds value at the next seconds event. Writing the calibration word restarts the divider, so the next second falls exactly one full period after the write. A 32-bit alarm comparator and the seconds event feed two interrupt sources. Each source has a status bit that software clears by writing 1 to it. Each also has an enable bit that is set through one offset, cleared through another and read back through a third. Two plain storage bits in a control word complete the map.

Top module: `sec_timekeeper`

## Requirements
- R1: After a synchronous active-high reset, the register contents are as follows. Calibration reads 0x198233. Seconds, staged time, alarm, tick count, status, enable mask and control all read 0. Both interrupt outputs are low.
- R2: Each `osc_tick` pulse increments the tick count, which reads at offset 0x14. On a pulse that finds the count equal to the limit, a seconds event occurs and the count returns to 0. The limit is calibration bits 15:0, plus one when the current second is stretched. With no pulse the count holds.
- R3: A seconds event with no staged time increments the seconds value, which reads at offset 0x10. The increment wraps from 0xFFFFFFFF to 0.
- R4: A write to offset 0x00 stages a new time, which reads back at offset 0x04. At the next seconds event the staged value replaces the seconds value instead of the increment, and the staged state then clears. A write in the same cycle as that event stays staged for the event after it.
- R5: A write to offset 0x08 stores wdata bits 20:0 as the calibration word, which reads back at offset 0x0C. The same write clears the tick count, the fraction accumulator and the stretch flag. An oscillator pulse in that same cycle is discarded.
- R6: When calibration bit 20 is set, each seconds event adds bits 19:16 to a 4-bit accumulator. A carry out of that addition stretches the next second by one tick, so each fraction unit adds one tick per 16 seconds. With bit 20 clear, no second is stretched.
- R7: The alarm value is written and read at offset 0x18. Status bit 1 is set in the first cycle in which the seconds value equals the alarm after being unequal. Equality that holds out of reset does not set it.
- R8: Status at offset 0x20 holds bit 0 for the seconds event and bit 1 for the alarm. Writing 1 to a bit clears it. A set in the same cycle overrides the clear.
- R9: Writing 1s to offset 0x28 sets those enable bits, and writing 1s to offset 0x2C clears them. Offset 0x24 reads the enables, with 1 meaning enabled and bit 0/1 matching the status bits.
- R10: `irq_sec` equals status bit 0 AND enable bit 0. `irq_alarm` equals status bit 1 AND enable bit 1. Both are levels.
- R11: Offset 0x40 stores wdata bits 31 and 24 and reads them back in place. All other bits read 0.
- R12: The write-only offsets (0x00, 0x08, 0x28, 0x2C) and unmapped offsets read 0. Writes to read-only offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_tick | input | 1 | One-cycle oscillator enable pulse |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| irq_sec | output | 1 | Seconds interrupt level |
| irq_alarm | output | 1 | Alarm interrupt level |

## Verification
The bench goes after the seconds rollover from 0xFFFFFFFF. A design that saturated or carried wrongly would read a wrong value there. It checks the seconds value in the window between a time write and the next event. A design that loaded the value at once would show the new time a second early, and one that kept the staged flag would reload on every event. Calibration writes land in the middle of a second and next to oscillator pulses. A divider that was not restarted would fire its next event early. The fraction patterns run across 16 or more seconds, so a lost accumulator carry or a stretch applied to the wrong second shifts the event cycles. Status clears are issued in the same cycle as new sets, and the alarm is written equal to the running time. Each of these exposes a wrong priority or a missing edge detect.

// File: rtl/stk_pkg.sv
package stk_pkg;

    localparam int SEC_W  = 32;
    localparam int TICK_W = 16;
    localparam int FRAC_W = 4;
    localparam int CAL_W  = TICK_W + FRAC_W + 1;
    localparam int CNT_W  = TICK_W + 1;
    localparam int NIRQ   = 2;

    typedef struct packed {
        logic              fen;
        logic [FRAC_W-1:0] frac;
        logic [TICK_W-1:0] limit;
    } cal_t;

    localparam cal_t CAL_RST = cal_t'(21'h198233);

    // interrupt source index
    typedef enum int { SRC_SEC = 0, SRC_ALARM = 1 } irq_src_e;

    // register offsets (software decodes these)
    localparam logic [7:0] OFF_SET_WR = 8'h00;
    localparam logic [7:0] OFF_SET_RD = 8'h04;
    localparam logic [7:0] OFF_CAL_WR = 8'h08;
    localparam logic [7:0] OFF_CAL_RD = 8'h0C;
    localparam logic [7:0] OFF_SECS   = 8'h10;
    localparam logic [7:0] OFF_TICK   = 8'h14;
    localparam logic [7:0] OFF_ALARM  = 8'h18;
    localparam logic [7:0] OFF_STS    = 8'h20;
    localparam logic [7:0] OFF_IEN    = 8'h24;
    localparam logic [7:0] OFF_IEN_S  = 8'h28;
    localparam logic [7:0] OFF_IEN_C  = 8'h2C;
    localparam logic [7:0] OFF_CTRL   = 8'h40;

    localparam int CTRL_BAT_BIT = 31;
    localparam int CTRL_OSC_BIT = 24;

    function automatic logic [CNT_W-1:0] tick_limit(input cal_t c, input logic stretch);
        return {1'b0, c.limit} + CNT_W'(stretch);
    endfunction

endpackage

// File: rtl/stk_tick_gen.sv
module stk_tick_gen
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             osc_tick,
    input  logic             cal_wr,
    input  cal_t             cal_new,
    output cal_t             cal_q,
    output logic [CNT_W-1:0] tick_cnt,
    output logic             sec_evt
);
    logic [FRAC_W-1:0] acc_q;
    logic              stretch_q;
    logic [FRAC_W:0]   acc_sum;

    assign acc_sum = {1'b0, acc_q} + {1'b0, cal_q.frac};
    assign sec_evt = osc_tick && !cal_wr && (tick_cnt == tick_limit(cal_q, stretch_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            cal_q     <= CAL_RST;
            tick_cnt  <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (cal_wr) begin
            cal_q     <= cal_new;
            tick_cnt  <= '0;
            acc_q     <= '0;
            stretch_q <= 1'b0;
        end else if (osc_tick) begin
            if (sec_evt) begin
                tick_cnt <= '0;
                if (cal_q.fen) begin
                    acc_q     <= acc_sum[FRAC_W-1:0];
                    stretch_q <= acc_sum[FRAC_W];
                end else begin
                    stretch_q <= 1'b0;
                end
            end else begin
                tick_cnt <= tick_cnt + CNT_W'(1);
            end
        end
    end

    a_r5_cal_restart: assert property (@(posedge clk) disable iff (rst)
        cal_wr |=> (tick_cnt == '0));
    a_r2_evt_wrap: assert property (@(posedge clk) disable iff (rst)
        sec_evt |=> (tick_cnt == '0));
    a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!osc_tick && !cal_wr) |=> $stable(tick_cnt));

endmodule

// File: rtl/stk_sec_count.sv
module stk_sec_count
    import stk_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sec_evt,
    input  logic             set_wr,
    input  logic [SEC_W-1:0] set_data,
    input  logic             alarm_wr,
    input  logic [SEC_W-1:0] alarm_data,
    output logic [SEC_W-1:0] secs_q,
    output logic [SEC_W-1:0] set_q,
    output logic [SEC_W-1:0] alarm_q,
    output logic             alarm_hit
);
    logic pend_q;
    logic match, match_d;

    assign match     = (secs_q == alarm_q);
    assign alarm_hit = match && !match_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            secs_q  <= '0;
            set_q   <= '0;
            pend_q  <= 1'b0;
            alarm_q <= '0;
            match_d <= 1'b1;
        end else begin
            match_d <= match;
            if (sec_evt) begin
                secs_q <= pend_q ? set_q : secs_q + SEC_W'(1);
                pend_q <= 1'b0;
            end
            if (set_wr) begin
                set_q  <= set_data;
                pend_q <= 1'b1;
            end
            if (alarm_wr)
                alarm_q <= alarm_data;
        end
    end

    a_r3_increment: assert property (@(posedge clk) disable iff (rst)
        (sec_evt && !pend_q) |=> (secs_q == $past(secs_q) + SEC_W'(1)));
    a_r4_staged_load: assert property (@(posedge clk) disable iff (rst)
        (sec_evt && pend_q) |=> (secs_q == $past(set_q)));
    a_r4_no_early_load: assert property (@(posedge clk) disable iff (rst)
        !sec_evt |=> $stable(secs_q));

endmodule

// File: rtl/stk_irq_ctrl.sv
module stk_irq_ctrl #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] src_set,
    input  logic         clr_wr,
    input  logic         en_wr,
    input  logic         dis_wr,
    input  logic [N-1:0] wbits,
    output logic [N-1:0] sts_q,
    output logic [N-1:0] ien_q,
    output logic [N-1:0] irq
);
    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk) begin
            if (rst) begin
                sts_q[i] <= 1'b0;
                ien_q[i] <= 1'b0;
            end else begin
                if (src_set[i])
                    sts_q[i] <= 1'b1;
                else if (clr_wr && wbits[i])
                    sts_q[i] <= 1'b0;
                if (en_wr && wbits[i])
                    ien_q[i] <= 1'b1;
                else if (dis_wr && wbits[i])
                    ien_q[i] <= 1'b0;
            end
        end
        assign irq[i] = sts_q[i] & ien_q[i];

        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            src_set[i] |=> sts_q[i]);
        a_r8_w1c: assert property (@(posedge clk) disable iff (rst)
            (clr_wr && wbits[i] && !src_set[i]) |=> !sts_q[i]);
        a_r9_enable: assert property (@(posedge clk) disable iff (rst)
            (en_wr && wbits[i]) |=> ien_q[i]);
        a_r9_disable: assert property (@(posedge clk) disable iff (rst)
            (dis_wr && wbits[i]) |=> !ien_q[i]);
    end

endmodule

// File: rtl/sec_timekeeper.sv
module sec_timekeeper
    import stk_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              osc_tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              irq_sec,
    output logic              irq_alarm
);
    cal_t             cal_q;
    logic [CNT_W-1:0] tick_cnt;
    logic             sec_evt;
    logic [SEC_W-1:0] secs_q, set_q, alarm_q;
    logic             alarm_hit;
    logic [NIRQ-1:0]  sts_q, ien_q, irq_v, src_set;
    logic             bat_q, osc_q;

    logic wr_set, wr_cal, wr_alarm, wr_sts, wr_en_s, wr_en_c, wr_ctrl;

    assign wr_set   = wr_en && (addr == ADDR_W'(OFF_SET_WR));
    assign wr_cal   = wr_en && (addr == ADDR_W'(OFF_CAL_WR));
    assign wr_alarm = wr_en && (addr == ADDR_W'(OFF_ALARM));
    assign wr_sts   = wr_en && (addr == ADDR_W'(OFF_STS));
    assign wr_en_s  = wr_en && (addr == ADDR_W'(OFF_IEN_S));
    assign wr_en_c  = wr_en && (addr == ADDR_W'(OFF_IEN_C));
    assign wr_ctrl  = wr_en && (addr == ADDR_W'(OFF_CTRL));

    stk_tick_gen u_tick (
        .clk      (clk),
        .rst      (rst),
        .osc_tick (osc_tick),
        .cal_wr   (wr_cal),
        .cal_new  (cal_t'(wdata[CAL_W-1:0])),
        .cal_q    (cal_q),
        .tick_cnt (tick_cnt),
        .sec_evt  (sec_evt)
    );

    stk_sec_count u_secs (
        .clk        (clk),
        .rst        (rst),
        .sec_evt    (sec_evt),
        .set_wr     (wr_set),
        .set_data   (wdata),
        .alarm_wr   (wr_alarm),
        .alarm_data (wdata),
        .secs_q     (secs_q),
        .set_q      (set_q),
        .alarm_q    (alarm_q),
        .alarm_hit  (alarm_hit)
    );

    always_comb begin
        src_set            = '0;
        src_set[SRC_SEC]   = sec_evt;
        src_set[SRC_ALARM] = alarm_hit;
    end

    stk_irq_ctrl #(.N(NIRQ)) u_irq (
        .clk     (clk),
        .rst     (rst),
        .src_set (src_set),
        .clr_wr  (wr_sts),
        .en_wr   (wr_en_s),
        .dis_wr  (wr_en_c),
        .wbits   (wdata[NIRQ-1:0]),
        .sts_q   (sts_q),
        .ien_q   (ien_q),
        .irq     (irq_v)
    );

    assign irq_sec   = irq_v[SRC_SEC];
    assign irq_alarm = irq_v[SRC_ALARM];

    always_ff @(posedge clk) begin
        if (rst) begin
            bat_q <= 1'b0;
            osc_q <= 1'b0;
        end else if (wr_ctrl) begin
            bat_q <= wdata[CTRL_BAT_BIT];
            osc_q <= wdata[CTRL_OSC_BIT];
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(OFF_SET_RD): rdata = set_q;
            ADDR_W'(OFF_CAL_RD): rdata = 32'(cal_q);
            ADDR_W'(OFF_SECS):   rdata = secs_q;
            ADDR_W'(OFF_TICK):   rdata = 32'(tick_cnt);
            ADDR_W'(OFF_ALARM):  rdata = alarm_q;
            ADDR_W'(OFF_STS):    rdata = 32'(sts_q);
            ADDR_W'(OFF_IEN):    rdata = 32'(ien_q);
            ADDR_W'(OFF_CTRL): begin
                rdata[CTRL_BAT_BIT] = bat_q;
                rdata[CTRL_OSC_BIT] = osc_q;
            end
            default: rdata = '0;
        endcase
    end

    a_r7_alarm_flag: assert property (@(posedge clk) disable iff (rst)
        alarm_hit |=> sts_q[SRC_ALARM]);
    a_r11_ctrl_store: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (bat_q == $past(wdata[CTRL_BAT_BIT])));

endmodule

// File: tb/tb_sec_timekeeper.sv
module tb_sec_timekeeper;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        osc_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h10;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_sec, irq_alarm;

    int n_cmp = 0;
    int n_bad = 0;
    int osc_div = 0;
    int cyc = 0;
    bit chk_en = 0;
    bit done = 0;

    always #2 clk = ~clk;   // 250 MHz

    sec_timekeeper dut (
        .clk(clk), .rst(rst), .osc_tick(osc_tick), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq_sec(irq_sec), .irq_alarm(irq_alarm)
    );

    // ---------------- behavioural reference model ----------------
    bit [31:0] m_cal, m_secs, m_set, m_alarm, m_ctrl;
    int unsigned m_cnt, m_acc;
    bit m_str, m_pend, m_prev;
    bit [1:0] m_sts, m_ien;

    function automatic bit [31:0] model_read(input bit [7:0] a);
        case (a)
            8'h04: return m_set;
            8'h0C: return m_cal;
            8'h10: return m_secs;
            8'h14: return 32'(m_cnt);
            8'h18: return m_alarm;
            8'h20: return {30'd0, m_sts};
            8'h24: return {30'd0, m_ien};
            8'h40: return m_ctrl;
            default: return 32'd0;
        endcase
    endfunction

    function automatic string req_of(input bit [7:0] a);
        case (a)
            8'h04: return "R4";
            8'h0C: return "R5";
            8'h10: return "R3";
            8'h14: return "R2";
            8'h18: return "R7";
            8'h20: return "R8";
            8'h24: return "R9";
            8'h40: return "R11";
            default: return "R12";
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cal = 32'h198233; m_secs = 0; m_set = 0; m_alarm = 0; m_ctrl = 0;
            m_cnt = 0; m_acc = 0; m_str = 0; m_pend = 0; m_prev = 1;
            m_sts = 0; m_ien = 0;
        end else begin
            bit ev, ahit, match;
            int unsigned lim, sum;
            ev = 0;
            match = (m_secs == m_alarm);
            ahit = match && !m_prev;
            m_prev = match;
            lim = (m_cal & 32'hFFFF) + 32'(m_str);
            if (wr_en && addr == 8'h08) begin
                m_cal = wdata & 32'h1FFFFF; m_cnt = 0; m_acc = 0; m_str = 0;
            end else if (osc_tick) begin
                if (m_cnt == lim) begin
                    ev = 1; m_cnt = 0;
                    if (m_cal[20]) begin
                        sum = m_acc + ((m_cal >> 16) & 15);
                        m_acc = sum & 15; m_str = (sum >= 16);
                    end else m_str = 0;
                end else m_cnt++;
            end
            if (ev) begin
                m_secs = m_pend ? m_set : m_secs + 1;
                m_pend = 0;
            end
            if (wr_en && addr == 8'h00) begin m_set = wdata; m_pend = 1; end
            if (wr_en && addr == 8'h18) m_alarm = wdata;
            if (wr_en && addr == 8'h20) m_sts = m_sts & ~wdata[1:0];
            if (ev) m_sts[0] = 1;
            if (ahit) m_sts[1] = 1;
            if (wr_en && addr == 8'h28) m_ien = m_ien | wdata[1:0];
            if (wr_en && addr == 8'h2C) m_ien = m_ien & ~wdata[1:0];
            if (wr_en && addr == 8'h40) m_ctrl = wdata & 32'h81000000;
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        #1;
        if (chk_en && !done) begin
            bit [31:0] exp_rd;
            exp_rd = model_read(addr);
            n_cmp++;
            if (rdata !== exp_rd) begin
                n_bad++;
                $display("FAIL %s addr=%h rdata actual=%h expected=%h t=%0t",
                         req_of(addr), addr, rdata, exp_rd, $time);
            end
            n_cmp++;
            if ({irq_alarm, irq_sec} !== (m_sts & m_ien)) begin
                n_bad++;
                $display("FAIL R10 irq actual=%b expected=%b t=%0t",
                         {irq_alarm, irq_sec}, m_sts & m_ien, $time);
            end
        end
    end

    // oscillator enable pattern
    always @(negedge clk) begin
        cyc++;
        osc_tick = (osc_div != 0) && (cyc % osc_div == 0);
    end

    task automatic wr(input bit [7:0] a, input bit [31:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
    endtask

    task automatic idle(input int n, input bit [7:0] a);
        addr = a;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        chk_en = 1;
        // R1 reset state, R12 zero reads of write-only offsets
        foreach (reset_addrs[i]) idle(1, reset_addrs[i]);

        // R2 R3: short period, no fraction, oscillator every cycle
        osc_div = 1;
        wr(8'h08, 32'h0000_0009);
        for (int i = 0; i < 60; i++) idle(1, (i % 2) ? 8'h10 : 8'h14);

        // R4 staged load near the wrap point, then R3 rollover
        wr(8'h00, 32'hFFFF_FFFE);
        idle(3, 8'h04);
        idle(3, 8'h10);
        idle(40, 8'h10);

        // R9 R10 seconds interrupt, R8 clear racing new sets
        wr(8'h28, 32'h1);
        idle(5, 8'h24);
        for (int i = 0; i < 12; i++) begin wr(8'h20, 32'h3); idle(i % 5, 8'h20); end
        wr(8'h2C, 32'h1);
        idle(3, 8'h24);

        // R5 calibration written mid-second and beside oscillator pulses
        osc_div = 3;
        for (int i = 0; i < 6; i++) begin
            idle(7 + i, 8'h14);
            wr(8'h08, 32'h0000_0004 + 32'(i));
            idle(2, 8'h0C);
        end
        idle(60, 8'h14);

        // R6 fractional stretch over more than 16 seconds
        osc_div = 1;
        wr(8'h08, 32'h0013_0004);
        idle(120, 8'h14);
        wr(8'h08, 32'h001F_0002);
        idle(80, 8'h10);
        wr(8'h08, 32'h0005_0003);   // fraction present but disabled
        idle(60, 8'h14);

        // R7 alarm ahead of time and equal to the running time
        wr(8'h28, 32'h2);
        wr(8'h08, 32'h0000_0005);
        wr(8'h00, 32'd100);
        idle(8, 8'h10);
        wr(8'h18, 32'd103);
        idle(30, 8'h20);
        wr(8'h20, 32'h2);
        wr(8'h18, m_secs);
        idle(4, 8'h20);
        wr(8'h20, 32'h2);
        idle(4, 8'h18);

        // R4 time writes landing on and around seconds events
        for (int i = 0; i < 10; i++) begin
            wr(8'h00, 32'h1000 + 32'(i));
            idle(i % 6, 8'h10);
        end
        idle(20, 8'h04);

        // R11 control storage bits, R12 writes to read-only offsets
        wr(8'h40, 32'hFFFF_FFFF);
        idle(2, 8'h40);
        wr(8'h40, 32'h0100_0000);
        idle(2, 8'h40);
        wr(8'h10, 32'hDEAD_BEEF);
        wr(8'h14, 32'h1234);
        wr(8'h24, 32'h3);
        wr(8'h04, 32'h55);
        idle(2, 8'h10);
        idle(1, 8'h24);
        idle(1, 8'h04);
        idle(1, 8'h30);

        // R2: no oscillator pulses, count holds
        osc_div = 0;
        idle(20, 8'h14);

        finish_run();
    end

    bit [7:0] reset_addrs [12] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14,
                                   8'h18, 8'h20, 8'h24, 8'h28, 8'h2C, 8'h40};

endmodule